// File: doc/BRIEF.md
# Polarity-Programmable Level Interrupt Combiner

This block merges a small group of external signal lines into one interrupt request. Each line first passes through a two-flop synchronizer. It then passes through a per-line inversion stage and a per-line enable gate. The request output is high while at least one enabled line, after inversion, is high. The output is level-sensitive and active high. Nothing is latched, so the request falls as soon as the condition goes away.

Software uses the inversion bit to pick the active level of each line. It leaves the bit clear for a line that idles low and sets it for a line that idles high. The inversion bit can also re-arm a level interrupt without any clear register. Once a line has been serviced, flipping its inversion bit makes the current level look idle, and the request drops on the clock that captures the write. A read-only status word shows the synchronized, post-inversion level of every line. With several lines enabled, the host compares this word against an earlier snapshot to find which line moved. A line must be held at its active level until the host has serviced it, because pulses narrower than the synchronizer window are not caught.

Top module: `lvl_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable word and the inversion word are both zero, the status word reads zero while the lines are low, and the request output is low.
- R2: A write to address 0 loads the enable word from write data bits [NUM_SRC-1:0]. Reading address 0 returns that word, with every higher data bit read as zero.
- R3: A write to address 1 loads the inversion word from write data bits [NUM_SRC-1:0]. Reading address 1 returns that word, with every higher data bit read as zero.
- R4: Reading address 2 returns, in bit i, the synchronized level of line i XOR inversion bit i. Every higher data bit reads as zero.
- R5: The request is high exactly when some bit i has both the post-inversion level i and enable bit i at 1. With the enable word at zero, the request stays low for any line values.
- R6: A change on a line reaches the status word and the request after exactly two rising clock edges, and not after one.
- R7: A change to the inversion word shows on the request and the status word right after the rising edge that captures the write. No further cycle is needed.
- R8: Writes to address 2 (status) and to address 3 (unused) change neither the enable word nor the inversion word. Reading address 3 returns zero.
- R9: The request has no memory. It stays high for as long as an enabled line stays active, and it falls two edges after that line returns to its idle level.
- R10: Flipping the inversion bit of an active, enabled line drops the request when no other enabled line is active. Once the line then returns to its old idle level, the request is raised again.
- R11: Bit i of the enable word, the inversion word and the status word all act on line i, which is input src_in[i], and on no other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | NUM_SRC | Asynchronous external interrupt lines |
| reg_wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| reg_addr | input | 2 | Register address: 0 enable, 1 inversion, 2 status, 3 unused |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_req | output | 1 | Level-sensitive, active-high interrupt request |

## Verification
The bench builds the block with its defaults: four lines, a two-stage synchronizer and an 8-bit data bus. Because the bus is twice as wide as the line count, writes with set upper bits show that the unused read bits stay at zero. The two-stage depth makes the one-edge-versus-two-edge latency boundary visible. With four lines, each enable, inversion and status bit can be walked one-hot to prove that it acts on its own line only.

// File: rtl/lvl_irq_pkg.sv
// Package: shared register address map and bus width constants for the
// level interrupt combiner. Assumes a four-word register space.
package lvl_irq_pkg;

    localparam int REG_ADDR_W = 2;

    // Register selector; the numeric codes are the bus addresses.
    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_INVERT = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/lvl_irq_sync.sv
// Module: per-line multi-flop synchronizer.
// Brings each asynchronous input line into the clk domain through a chain of
// STAGES flops. Assumes lines are held far longer than STAGES clock periods;
// shorter pulses may be lost. All flops clear on synchronous reset.
module lvl_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    generate
        genvar b;
        for (b = 0; b < WIDTH; b++) begin : g_line
            logic [STAGES-1:0] chain_q;

            // Shift the raw line into the flop chain one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else if (STAGES == 1) begin
                    chain_q[0] <= async_in[b];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                end
            end

            assign sync_out[b] = chain_q[LAST];
        end
    endgenerate

endmodule

// File: rtl/lvl_irq_regs.sv
// Module: register file for the combiner.
// Holds the enable and inversion words and serves the read mux. The status
// word is supplied by the combine stage and is read-only here. Assumes
// NUM_SRC <= DATA_W; unused data bits read as zero and are ignored on write.
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_SRC-1:0]    status_lvl,
    output logic [NUM_SRC-1:0]    enable_q,
    output logic [NUM_SRC-1:0]    invert_q,
    output logic [DATA_W-1:0]     rdata
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    reg_sel_e             sel;
    logic                 hit_enable;
    logic                 hit_invert;
    logic [NUM_SRC-1:0]   wr_field;

    // Decode the address into a register selector and write hits.
    always_comb begin
        sel        = reg_sel_e'(addr);
        hit_enable = wr_en && (sel == SEL_ENABLE);
        hit_invert = wr_en && (sel == SEL_INVERT);
        wr_field   = wdata[NUM_SRC-1:0];
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_SRC];
        end
    endgenerate

    // Enable word: cleared by reset, loaded by a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (hit_enable) begin
            enable_q <= wr_field;
        end
    end

    // Inversion word: reset to non-inverted, loaded by a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invert_q <= '0;
        end else if (hit_invert) begin
            invert_q <= wr_field;
        end
    end

    // Read mux: zero-extend the selected word; the spare address reads zero.
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ENABLE: rdata[NUM_SRC-1:0] = enable_q;
            SEL_INVERT: rdata[NUM_SRC-1:0] = invert_q;
            SEL_STATUS: rdata[NUM_SRC-1:0] = status_lvl;
            SEL_SPARE:  rdata = '0;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/lvl_irq_combine.sv
// Module: polarity and enable logic for each line, plus the OR tree.
// Purely combinational: each synchronized line is XORed with its inversion
// bit, gated by its enable bit, and the gated terms are ORed into one
// request. Assumes inputs are already in the clk domain.
module lvl_irq_combine #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] sync_lvl,
    input  logic [NUM_SRC-1:0] invert,
    input  logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] post_lvl,
    output logic               req
);

    logic [NUM_SRC-1:0] gated;

    generate
        genvar s;
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            // Apply the line's polarity, then its enable gate.
            always_comb begin
                post_lvl[s] = sync_lvl[s] ^ invert[s];
                gated[s]    = post_lvl[s] & enable[s];
            end
        end
    endgenerate

    // Any enabled, active line raises the request.
    always_comb begin
        req = |gated;
    end

endmodule

// File: rtl/lvl_irq_unit.sv
// Module: top of the polarity-programmable level interrupt combiner.
// Synchronizes NUM_SRC external lines, applies per-line inversion and enable
// from a small register bus, and drives one active-high level request.
// Assumes the host holds each line active until serviced and re-arms a line
// by flipping its inversion bit.
module lvl_irq_unit
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_in,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_req
);

    logic [NUM_SRC-1:0] sync_lvl;
    logic [NUM_SRC-1:0] src_level;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pol_q;

    lvl_irq_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_in),
        .sync_out (sync_lvl)
    );

    lvl_irq_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status_lvl (src_level),
        .enable_q   (mask_q),
        .invert_q   (pol_q),
        .rdata      (reg_rdata)
    );

    lvl_irq_combine #(
        .NUM_SRC (NUM_SRC)
    ) u_comb (
        .sync_lvl (sync_lvl),
        .invert   (pol_q),
        .enable   (mask_q),
        .post_lvl (src_level),
        .req      (irq_req)
    );

endmodule

// File: rtl/lvl_irq_unit_chk.sv
// Checker: temporal properties of lvl_irq_unit, bound into the top module.
// Keeps its own delay line of the raw lines to check synchronizer latency.
module lvl_irq_unit_chk
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_in,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [NUM_SRC-1:0]    mask_q,
    input  logic [NUM_SRC-1:0]    pol_q,
    input  logic [NUM_SRC-1:0]    src_level,
    input  logic                  irq_req
);

    logic [NUM_SRC-1:0] dly_q [SYNC_STAGES];

    // Reference delay line of the raw lines, cleared like the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) dly_q[k] <= '0;
        end else begin
            dly_q[0] <= src_in;
            for (int k = 1; k < SYNC_STAGES; k++) dly_q[k] <= dly_q[k-1];
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0) && (pol_q == '0));

    // R2
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == SEL_ENABLE) |=> mask_q == $past(reg_wdata[NUM_SRC-1:0]));

    // R3
    invert_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == SEL_INVERT) |=> pol_q == $past(reg_wdata[NUM_SRC-1:0]));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_req);

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_level == (dly_q[SYNC_STAGES-1] ^ pol_q));

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_addr == SEL_STATUS || reg_addr == SEL_SPARE))
        |=> $stable(mask_q) && $stable(pol_q));

    // R9
    req_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((src_level & mask_q) != '0));

endmodule

bind lvl_irq_unit lvl_irq_unit_chk #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mask_q    (mask_q),
    .pol_q     (pol_q),
    .src_level (src_level),
    .irq_req   (irq_req)
);

// File: tb/test_lvl_irq_unit.sv
// Directed bench for lvl_irq_unit: one task per scenario, each self-checking.
module test_lvl_irq_unit;

    localparam int NUM_SRC = 4;
    localparam int DATA_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_in = '0;
    logic              reg_wr_en = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lvl_irq_unit #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (2),
        .DATA_W      (DATA_W)
    ) i_lvl_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance n rising edges, then settle away from the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        step(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] d;
        check("R1 irq", irq_req, 0);
        rd(2'd0, d); check("R1 enable", d, 0);
        rd(2'd1, d); check("R1 invert", d, 0);
        rd(2'd2, d); check("R1 status", d, 0);
    endtask

    task automatic t_reg_rw;
        logic [DATA_W-1:0] d;
        wr(2'd0, 8'hF5); rd(2'd0, d); check("R2 enable readback", d, 8'h05);
        wr(2'd1, 8'hAA); rd(2'd1, d); check("R3 invert readback", d, 8'h0A);
        // R4/R7: inversion alone moves status right after the capturing edge
        rd(2'd2, d); check("R4 status inverted idle", d, 8'h0A);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        rd(2'd2, d); check("R4 status cleared", d, 8'h00);
    endtask

    task automatic t_latency;
        logic [DATA_W-1:0] d;
        src_in = 4'b1001;
        step(1); rd(2'd2, d); check("R6 one edge no change", d, 8'h00);
        step(1); rd(2'd2, d); check("R6 two edges status", d, 8'h09);
        wr(2'd1, 8'h01); rd(2'd2, d); check("R4 status with invert", d, 8'h08);
        wr(2'd1, 8'h00);
        src_in = '0; step(2);
    endtask

    task automatic t_per_line;
        logic [DATA_W-1:0] d;
        // R5: enable word zero keeps request low with all lines high
        src_in = 4'hF; step(2);
        check("R5 all masked", irq_req, 0);
        src_in = '0; step(2);
        for (int i = 0; i < NUM_SRC; i++) begin
            src_in = NUM_SRC'(1) << i; step(2);
            rd(2'd2, d); check("R11 status bit", d, 8'(1 << i));
            wr(2'd0, 8'(1 << ((i + 1) % NUM_SRC)));
            check("R11 other enable", irq_req, 0);
            wr(2'd0, 8'(1 << i));
            check("R5 own enable", irq_req, 1);
            wr(2'd0, 8'h00);
            src_in = '0; step(2);
        end
    endtask

    task automatic t_rearm;
        wr(2'd0, 8'h04);
        src_in = 4'b0100; step(2);
        check("R10 active", irq_req, 1);
        reg_addr = 2'd1; reg_wdata = 8'h04; reg_wr_en = 1'b1; #1;
        check("R7 before edge", irq_req, 1);
        @(posedge clk); #2; reg_wr_en = 1'b0;
        check("R7 after capture edge", irq_req, 0);
        check("R10 rearmed low", irq_req, 0);
        src_in = '0;
        step(1); check("R10 one edge", irq_req, 0);
        step(1); check("R10 idle now active", irq_req, 1);
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    endtask

    task automatic t_ro_addr;
        logic [DATA_W-1:0] d;
        wr(2'd0, 8'h03); wr(2'd1, 8'h05);
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        rd(2'd0, d); check("R8 enable kept", d, 8'h03);
        rd(2'd1, d); check("R8 invert kept", d, 8'h05);
        rd(2'd3, d); check("R8 spare reads zero", d, 8'h00);
        check("R8 irq from kept regs", irq_req, 1);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_level;
        wr(2'd0, 8'h0F);
        src_in = 4'b1000; step(2);
        for (int c = 0; c < 5; c++) begin
            check("R9 held high", irq_req, 1);
            step(1);
        end
        src_in = '0;
        step(1); check("R9 still high one edge", irq_req, 1);
        step(1); check("R9 falls", irq_req, 0);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_reg_rw();
        t_latency();
        t_per_line();
        t_rearm();
        t_ro_addr();
        t_level();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule